// File: doc/BRIEF.md
# Data Watchpoint Access Matcher

This block is one data-watchpoint unit. It checks every memory access presented on its access inputs against a control word and a watch address that software loads through a small register-write port. When the unit is enabled and every programmed condition holds, it raises a registered event pulse. The conditions are the access direction, the privilege of the access, and the word address. Surrounding debug logic consumes the pulse.

The access direction is derived from four flags: read, write, memory hint and cache maintenance. A swap sets both read and write. A hint counts as a read and a cache-maintenance operation counts as a write. The privilege test looks only at the privilege attribute carried by the access itself. It ignores the mode the processor happens to be in. The control word has no defined value after reset, so software must write it before relying on any event.

Top module: `wpt_matcher`

## Requirements
- R1: When control bit 0 (enable) is 0, `wp_event` stays low whatever the other fields and accesses are.
- R2: The direction select in control bits [4:3] behaves as follows. Code 01 matches accesses with the read flag set, swaps included. Code 10 matches accesses with the write flag set, swaps and exclusive stores included. Code 11 matches either. Code 00 matches nothing.
- R3: An access with `acc_hint` set is classified as a read, and an access with `acc_cmo` set is classified as a write, for the direction test.
- R4: The privilege select in control bits [2:1] behaves as follows. Code 01 matches only accesses with `acc_priv`=1, code 10 only accesses with `acc_priv`=0, and code 11 matches both. The test uses the access's own privilege flag, so an unprivileged access fails code 01.
- R5: Privilege select code 00 never produces an event.
- R6: The address test compares `acc_addr[31:2]` for equality with bits [31:2] of the value last written with `cfg_sel`=1. Bits [1:0] of the access address are ignored.
- R7: A matching access with `acc_valid`=1 in cycle N gives `wp_event`=1 in cycle N+1 only. Back-to-back matching accesses give back-to-back pulses, and `acc_valid`=0 never gives an event.
- R8: A write on the configuration port (`cfg_sel`=0 for control, 1 for address) takes effect from the following cycle. An access in the same cycle as the write is judged against the old settings.
- R9: While reset is asserted and in the first cycle after it, `wp_event` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the watch address |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_rd | input | 1 | Access reads memory |
| acc_wr | input | 1 | Access writes memory |
| acc_hint | input | 1 | Access is a memory hint |
| acc_cmo | input | 1 | Access is a cache-maintenance operation |
| acc_priv | input | 1 | Access carries privileged attribute |
| wp_event | output | 1 | One-cycle watchpoint event |

## Verification
The assertions assume that the enable bit and the two select fields hold known values from the first configuration write onward. They also assume that access flags are only meaningful while `acc_valid` is high. The stimulus therefore writes the control word before its first check and keeps flags at zero on idle cycles. The bench's reference model tracks its own copy of the configuration and judges every cycle. It covers all direction and privilege codes, hint and cache-maintenance accesses, and address mismatches in high and low bits. It also covers writes that coincide with accesses.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  typedef enum logic [1:0] {
    LS_NONE  = 2'b00,
    LS_READ  = 2'b01,
    LS_WRITE = 2'b10,
    LS_EITHER = 2'b11
  } ls_sel_e;

  typedef enum logic [1:0] {
    PV_RSVD = 2'b00,
    PV_PRIV = 2'b01,
    PV_USER = 2'b10,
    PV_ALL  = 2'b11
  } pv_sel_e;

  // bit 0 enable, bits [2:1] privilege select, bits [4:3] direction select
  typedef struct packed {
    ls_sel_e ls;
    pv_sel_e pv;
    logic    en;
  } wctl_t;

  localparam int CTL_W = $bits(wctl_t);

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
  import wpt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 2,
  localparam int WA_W     = ADDR_W - ALIGN_LSB
) (
  input  logic              clk,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output wctl_t             ctl_o,
  output logic [WA_W-1:0]   wadr_o
);

  wctl_t           ctl_q, ctl_d;
  logic [WA_W-1:0] wadr_q, wadr_d;
  logic            ctl_ce, wadr_ce;

  // contents after reset are undefined by intent: no reset on these registers
  always_comb begin
    ctl_ce  = cfg_we && !cfg_sel;
    wadr_ce = cfg_we && cfg_sel;
    ctl_d   = wctl_t'(cfg_wdata[CTL_W-1:0]);
    wadr_d  = cfg_wdata[ADDR_W-1:ALIGN_LSB];
  end

  always_ff @(posedge clk) begin
    if (ctl_ce)  ctl_q  <= ctl_d;
    if (wadr_ce) wadr_q <= wadr_d;
  end

  assign ctl_o  = ctl_q;
  assign wadr_o = wadr_q;

endmodule

// File: rtl/wpt_access_class.sv
module wpt_access_class
  import wpt_pkg::*;
(
  input  wctl_t ctl,
  input  logic  acc_rd,
  input  logic  acc_wr,
  input  logic  acc_hint,
  input  logic  acc_cmo,
  input  logic  acc_priv,
  output logic  attr_ok
);

  logic is_read, is_write, dir_ok, pv_ok;

  always_comb begin
    // hints behave as reads, cache maintenance behaves as writes
    is_read  = acc_rd | acc_hint;
    is_write = acc_wr | acc_cmo;

    unique case (ctl.ls)
      LS_READ:   dir_ok = is_read;
      LS_WRITE:  dir_ok = is_write;
      LS_EITHER: dir_ok = is_read | is_write;
      default:   dir_ok = 1'b0;
    endcase

    unique case (ctl.pv)
      PV_PRIV: pv_ok = acc_priv;
      PV_USER: pv_ok = !acc_priv;
      PV_ALL:  pv_ok = 1'b1;
      default: pv_ok = 1'b0;
    endcase

    attr_ok = dir_ok & pv_ok;
  end

endmodule

// File: rtl/wpt_addr_cmp.sv
module wpt_addr_cmp #(
  parameter int WA_W = 30
) (
  input  logic [WA_W-1:0] acc_word,
  input  logic [WA_W-1:0] watch_word,
  output logic            hit
);

  assign hit = (acc_word == watch_word);

endmodule

// File: rtl/wpt_matcher.sv
module wpt_matcher
  import wpt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 2,
  localparam int WA_W     = ADDR_W - ALIGN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_hint,
  input  logic              acc_cmo,
  input  logic              acc_priv,
  output logic              wp_event
);

  wctl_t           ctl;
  logic [WA_W-1:0] wadr;
  logic            attr_ok, addr_hit;
  logic            evt_d, evt_q;
  logic            unused_lsb;

  assign unused_lsb = ^acc_addr[ALIGN_LSB-1:0];

  wpt_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)
  ) u_cfg (
    .clk(clk), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctl_o(ctl), .wadr_o(wadr)
  );

  wpt_access_class u_cls (
    .ctl(ctl), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_hint(acc_hint),
    .acc_cmo(acc_cmo), .acc_priv(acc_priv), .attr_ok(attr_ok)
  );

  wpt_addr_cmp #(.WA_W(WA_W)) u_cmp (
    .acc_word(acc_addr[ADDR_W-1:ALIGN_LSB]), .watch_word(wadr), .hit(addr_hit)
  );

  always_comb begin
    evt_d = acc_valid & ctl.en & attr_ok & addr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign wp_event = evt_q;

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> !wp_event);
  a_r2_dir_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ls == LS_NONE) |=> !wp_event);
  a_r5_priv_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pv == PV_RSVD) |=> !wp_event);
  a_r6_addr_equal: assert property (@(posedge clk) disable iff (!rst_n)
    wp_event |-> ($past(acc_addr[ADDR_W-1:ALIGN_LSB]) == $past(wadr)));
  a_r7_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !wp_event);
  a_r4_priv_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ctl.pv == PV_PRIV && !acc_priv) |=> !wp_event);

endmodule

// File: tb/sim_wpt_matcher.sv
`timescale 1ns/1ps
module sim_wpt_matcher;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_rd, acc_wr, acc_hint, acc_cmo, acc_priv;
  logic        wp_event;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural model state
  logic [4:0]  m_ctl;
  logic [29:0] m_wadr;

  always #2.5 clk = ~clk;

  wpt_matcher u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_hint(acc_hint), .acc_cmo(acc_cmo),
    .acc_priv(acc_priv), .wp_event(wp_event)
  );

  function automatic bit model_hit(input bit v, input logic [31:0] a,
      input bit rd, input bit wr, input bit hn, input bit cm, input bit pr);
    bit ld = rd || hn;
    bit st = wr || cm;
    bit dir, pv;
    case (m_ctl[4:3])
      2'b01: dir = ld;
      2'b10: dir = st;
      2'b11: dir = ld || st;
      default: dir = 0;
    endcase
    case (m_ctl[2:1])
      2'b01: pv = pr;
      2'b10: pv = !pr;
      2'b11: pv = 1;
      default: pv = 0;
    endcase
    return v && m_ctl[0] && dir && pv && (a[31:2] == m_wadr);
  endfunction

  task automatic check(input string tag, input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: wp_event=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare just after the next posedge
  task automatic cyc(input string tag, input bit v, input logic [31:0] a,
      input bit rd, input bit wr, input bit hn, input bit cm, input bit pr,
      input bit we = 0, input bit sel = 0, input logic [31:0] wd = '0);
    bit exp;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_rd = v & rd; acc_wr = v & wr;
    acc_hint = v & hn; acc_cmo = v & cm; acc_priv = pr;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    exp = model_hit(v, a, rd, wr, hn, cm, pr);
    if (we) begin
      if (sel) m_wadr = wd[31:2];
      else     m_ctl  = wd[4:0];
    end
    @(posedge clk); #1;
    check(tag, wp_event, exp);
  endtask

  task automatic wr_ctl(input logic [4:0] c);
    cyc("R8 cfg", 0, 0, 0, 0, 0, 0, 0, 1, 0, {27'd0, c});
  endtask

  task automatic wr_adr(input logic [31:0] a);
    cyc("R8 cfg", 0, 0, 0, 0, 0, 0, 0, 1, 1, a);
  endtask

  localparam logic [31:0] WA = 32'h4000_1238;

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 0; acc_addr = 0; acc_rd = 0; acc_wr = 0;
    acc_hint = 0; acc_cmo = 0; acc_priv = 0;
    m_ctl = 0; m_wadr = 0;
    repeat (3) @(posedge clk);
    #1 check("R9 reset", wp_event, 0);
    @(negedge clk); rst_n = 1;
    // program enable off first, then address
    wr_ctl(5'b11_11_0);
    wr_adr(WA);
    check("R9 after reset", wp_event, 0);
    // R1 disabled with everything else matching
    cyc("R1 disabled", 1, WA, 1, 1, 0, 0, 1);
    wr_ctl(5'b11_11_1);
    // R7 basic match, pulse one cycle, back-to-back
    cyc("R7 match", 1, WA, 1, 0, 0, 0, 1);
    cyc("R7 back-to-back", 1, WA, 0, 1, 0, 0, 0);
    cyc("R7 one cycle", 0, WA, 1, 0, 0, 0, 1);
    cyc("R7 valid low", 0, WA, 1, 1, 0, 0, 1);
    // R6 address: low bits ignored, others compared
    cyc("R6 low bits", 1, WA | 32'h3, 1, 0, 0, 0, 1);
    cyc("R6 bit2", 1, WA ^ 32'h4, 1, 0, 0, 0, 1);
    cyc("R6 bit31", 1, WA ^ 32'h8000_0000, 1, 0, 0, 0, 1);
    // R2 direction codes across reads, writes, swaps
    for (int ls = 0; ls < 4; ls++) begin
      wr_ctl({ls[1:0], 2'b11, 1'b1});
      cyc("R2 read", 1, WA, 1, 0, 0, 0, 1);
      cyc("R2 write", 1, WA, 0, 1, 0, 0, 1);
      cyc("R2 swap", 1, WA, 1, 1, 0, 0, 0);
      // R3 hint as read, cache maintenance as write
      cyc("R3 hint", 1, WA, 0, 0, 1, 0, 1);
      cyc("R3 cmo", 1, WA, 0, 0, 0, 1, 0);
    end
    // R4 / R5 privilege codes
    for (int pv = 0; pv < 4; pv++) begin
      wr_ctl({2'b11, pv[1:0], 1'b1});
      cyc("R4 priv access", 1, WA, 1, 0, 0, 0, 1);
      cyc("R4 unpriv access", 1, WA, 0, 1, 0, 0, 0);
      cyc("R5 reserved check", 1, WA, 1, 1, 0, 0, 1);
    end
    // R8 control write in same cycle as access uses old settings
    wr_ctl(5'b11_11_1);
    cyc("R8 same-cycle disable", 1, WA, 1, 0, 0, 0, 1, 1, 0, 32'h0000_001E);
    cyc("R8 now disabled", 1, WA, 1, 0, 0, 0, 1);
    cyc("R8 same-cycle enable", 1, WA, 1, 0, 0, 0, 1, 1, 0, 32'h0000_001F);
    cyc("R8 now enabled", 1, WA, 1, 0, 0, 0, 1);
    cyc("R8 same-cycle addr", 1, WA, 1, 0, 0, 0, 1, 1, 1, 32'h0000_0100);
    cyc("R8 old addr miss", 1, WA, 1, 0, 0, 0, 1);
    cyc("R8 new addr hit", 1, 32'h0000_0102, 0, 1, 0, 0, 0);
    cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule